// File: doc/BRIEF.md
# Sleep-Mode Clock Gating Controller

This block manages low-power entry and exit for a small microcontroller core. Software sets a one-bit sleep enable and a three-bit mode code in a control register. When the core then presents a sleep instruction, the controller halts the core. It also drops the clock enables of the domains that the chosen mode stops, and it may switch off the main oscillator. The mode also picks which wake sources are honoured while asleep.

A qualifying wake event restores every clock enable and the oscillator in the next cycle. The core is still held. It stays halted for an oscillator start-up count, used only in the modes that stop the oscillator, plus a fixed extra hold. It is then released to service the interrupt. If a reset request arrives during sleep, the controller runs the same wake sequence but raises a flag that tells the core to restart from the reset vector.

The wake inputs are grouped into four classes:
- edge-type external interrupts
- level-type external interrupts
- internal sources that need a running peripheral clock
- always-on internal sources

Top module: `slp_ctrl`

## Requirements
- R1: Sleep is entered only when the core presents `sleep_instr` while the stored enable bit (`ctl_wdata[0]`) is 1. A sleep instruction with the enable bit at 0 leaves `core_halt` low and every clock enable high.
- R2: Mode codes (`ctl_wdata[3:1]`) 100, 101 and 111 are reserved, and a sleep instruction under any of them has no effect.
- R3: Mode 000 (idle) clears only the CPU and flash enables. `dom_en` reads 5'b11100, with bit 0 CPU, 1 flash, 2 I/O, 3 ADC and 4 PLL, and `osc_en` stays 1.
- R4: Mode 001 (ADC quiet) keeps only the ADC clock: `dom_en` is 5'b01000 and `osc_en` is 1.
- R5: Modes 010 (deep power-down) and 011 (power-save) clear all five domain enables and `osc_en`.
- R6: Mode 110 (standby) clears all five domain enables but keeps `osc_en` at 1.
- R7: `wake_src` has four classes: bit 0 is an edge external interrupt, bit 1 a level external interrupt, bit 2 a clocked internal source and bit 3 an always-on source.
  - Idle accepts all four classes.
  - ADC quiet accepts bits 1 to 3.
  - The other modes accept only bits 1 and 3.
  - A source that is not accepted leaves the block asleep.
- R8: In the cycle after the wake edge, all clock enables and `osc_en` return to 1. `core_halt` stays high for exactly `STARTUP_CYC + HALT_EXTRA` cycles after that edge in modes 010 and 011, and for `HALT_EXTRA` cycles in the other modes.
- R9: A `wake_rst` pulse during sleep wakes the block with the same timing and sets `rst_vec`. An interrupt wake leaves `rst_vec` at 0, and the next sleep entry clears it.
- R10: Entering idle or ADC quiet while `adc_on` is 1 gives a single-cycle `adc_start` pulse. Entering any other mode gives no pulse.
- R11: After reset `core_halt`, `rst_vec` and `adc_start` are 0, all enables are 1, and the control register holds enable 0 and mode 000.
- R12: While the core runs, `wake_src` and `wake_rst` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 4 | Bit 0 sleep enable, bits 3:1 mode code |
| sleep_instr | input | 1 | Core executes a sleep instruction this cycle |
| adc_on | input | 1 | ADC is enabled |
| wake_src | input | 4 | Pending interrupt classes (see R7) |
| wake_rst | input | 1 | Reset request from any reset source |
| dom_en | output | 5 | Clock enables: CPU, flash, I/O, ADC, PLL |
| osc_en | output | 1 | Main oscillator enable |
| core_halt | output | 1 | Holds the core stopped |
| rst_vec | output | 1 | The last wake was caused by reset |
| adc_start | output | 1 | One-cycle ADC conversion request on entry |

## Verification
The bench goes after the halt length, which must be exact in both the short and the long case. A counter that is off by one, or that loads the oscillator delay in standby, would release the core a cycle early or many cycles late. It also offers wake sources that the current mode must refuse, such as an edge interrupt in deep power-down. A mask decoded from the wrong mode would wake the core from a state it should keep. Reserved codes, a cleared enable bit and a reset wake are exercised as well, so a missing qualifier, an unconditional ADC request or a stale `rst_vec` shows up as a mismatch against the cycle model.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam int MODE_W = 3;
   localparam int DOM_N  = 5;   // 0 cpu, 1 flash, 2 io, 3 adc, 4 pll
   localparam int SRC_N  = 4;   // 0 edge ext, 1 level ext, 2 clocked int, 3 always-on

   localparam logic [MODE_W-1:0] MD_IDLE  = 3'b000;
   localparam logic [MODE_W-1:0] MD_ADCQ  = 3'b001;
   localparam logic [MODE_W-1:0] MD_PDOWN = 3'b010;
   localparam logic [MODE_W-1:0] MD_PSAVE = 3'b011;
   localparam logic [MODE_W-1:0] MD_STBY  = 3'b110;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_WAKE  = 2'd2
   } slp_state_e;

   typedef struct packed {
      logic              valid;
      logic [DOM_N-1:0]  dom;
      logic              osc;
      logic [SRC_N-1:0]  wmask;
      logic              slow_start;
      logic              adc_kick;
   } mode_cfg_t;

endpackage

// File: rtl/slp_ctl_reg.sv
module slp_ctl_reg
   import slp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [MODE_W:0]   wdata,
   output logic              sl_en,
   output logic [MODE_W-1:0] sl_mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sl_en   <= 1'b0;
         sl_mode <= MD_IDLE;
      end else if (we) begin
         sl_en   <= wdata[0];
         sl_mode <= wdata[MODE_W:1];
      end
   end

endmodule

// File: rtl/slp_mode_dec.sv
module slp_mode_dec
   import slp_pkg::*;
(
   input  logic [MODE_W-1:0] mode,
   output mode_cfg_t         cfg
);

   // dom bits {pll, adc, io, flash, cpu}; wmask bits {always-on, clocked, level, edge}
   always_comb begin
      cfg = '0;
      case (mode)
         MD_IDLE: begin
            cfg.valid    = 1'b1;
            cfg.dom      = 5'b11100;
            cfg.osc      = 1'b1;
            cfg.wmask    = 4'b1111;
            cfg.adc_kick = 1'b1;
         end
         MD_ADCQ: begin
            cfg.valid    = 1'b1;
            cfg.dom      = 5'b01000;
            cfg.osc      = 1'b1;
            cfg.wmask    = 4'b1110;
            cfg.adc_kick = 1'b1;
         end
         MD_PDOWN, MD_PSAVE: begin
            cfg.valid      = 1'b1;
            cfg.wmask      = 4'b1010;
            cfg.slow_start = 1'b1;
         end
         MD_STBY: begin
            cfg.valid = 1'b1;
            cfg.osc   = 1'b1;
            cfg.wmask = 4'b1010;
         end
         default: cfg = '0;
      endcase
   end

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer #(
   parameter int STARTUP_CYC = 16,
   parameter int HALT_EXTRA  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic slow,
   input  logic active,
   output logic done
);

   localparam int LONG_D = STARTUP_CYC + HALT_EXTRA;
   localparam int CNT_W  = $clog2(LONG_D + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= slow ? CNT_W'(LONG_D - 1) : CNT_W'(HALT_EXTRA - 1);
      else if (active && cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign done = (cnt == '0);

   // R8: the count only moves while a wake sequence is in progress
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !load) |=> $stable(cnt));

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
   import slp_pkg::*;
#(
   parameter int STARTUP_CYC = 16,
   parameter int HALT_EXTRA  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [3:0]       ctl_wdata,
   input  logic             sleep_instr,
   input  logic             adc_on,
   input  logic [3:0]       wake_src,
   input  logic             wake_rst,
   output logic [4:0]       dom_en,
   output logic             osc_en,
   output logic             core_halt,
   output logic             rst_vec,
   output logic             adc_start
);

   generate
      if (HALT_EXTRA < 1) begin : g_bad_extra
         $error("HALT_EXTRA must be at least 1");
      end
      if (STARTUP_CYC < 0) begin : g_bad_start
         $error("STARTUP_CYC must not be negative");
      end
   endgenerate

   slp_state_e        st;
   logic              sl_en;
   logic [MODE_W-1:0] sl_mode;
   logic [MODE_W-1:0] held_mode;
   logic [MODE_W-1:0] dec_mode;
   mode_cfg_t         cfg;
   logic              wake_hit;
   logic              tmr_done;

   slp_ctl_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl_we),
      .wdata   (ctl_wdata),
      .sl_en   (sl_en),
      .sl_mode (sl_mode)
   );

   // running: decode the programmed code; asleep: decode the latched one
   assign dec_mode = (st == ST_RUN) ? sl_mode : held_mode;

   slp_mode_dec u_dec (
      .mode (dec_mode),
      .cfg  (cfg)
   );

   assign wake_hit = wake_rst || ((wake_src & cfg.wmask) != '0);

   slp_wake_timer #(
      .STARTUP_CYC (STARTUP_CYC),
      .HALT_EXTRA  (HALT_EXTRA)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (st == ST_SLEEP && wake_hit),
      .slow   (cfg.slow_start),
      .active (st == ST_WAKE),
      .done   (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_RUN;
         held_mode <= MD_IDLE;
         rst_vec   <= 1'b0;
         adc_start <= 1'b0;
      end else begin
         adc_start <= 1'b0;
         case (st)
            ST_RUN: begin
               if (sleep_instr && sl_en && cfg.valid) begin
                  st        <= ST_SLEEP;
                  held_mode <= sl_mode;
                  rst_vec   <= 1'b0;
                  adc_start <= adc_on & cfg.adc_kick;
               end
            end
            ST_SLEEP: begin
               if (wake_hit) begin
                  st      <= ST_WAKE;
                  rst_vec <= wake_rst;
               end
            end
            ST_WAKE: begin
               if (tmr_done) st <= ST_RUN;
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   assign core_halt = (st != ST_RUN);
   assign dom_en    = (st == ST_SLEEP) ? cfg.dom : '1;
   assign osc_en    = (st == ST_SLEEP) ? cfg.osc : 1'b1;

   // R1: a sleep instruction without the enable bit leaves the core running
   p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_instr && !sl_en) |=> !core_halt);

   // R2: reserved codes never enter sleep
   p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_instr && !cfg.valid) |=> !core_halt);

   // R11: a running core always sees every clock and the oscillator
   p_run_clocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !core_halt |-> (dom_en == 5'b11111 && osc_en));

   // R8: a reset wake restores clocks at once while still holding the core
   p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SLEEP && wake_rst) |=> (dom_en == 5'b11111 && osc_en && core_halt));

   // R9: the reset-vector flag rises only after a reset request
   p_rstvec_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_vec) |-> $past(wake_rst));

   // R10: the ADC request is a single-cycle pulse
   p_adc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);

endmodule

// File: tb/tb_slp_ctrl.sv
module tb_slp_ctrl;

   localparam int STARTUP = 16;
   localparam int EXTRA   = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [3:0] ctl_wdata = '0;
   logic       sleep_instr = 1'b0;
   logic       adc_on = 1'b0;
   logic [3:0] wake_src = '0;
   logic       wake_rst = 1'b0;
   logic [4:0] dom_en;
   logic       osc_en;
   logic       core_halt;
   logic       rst_vec;
   logic       adc_start;

   int    vectors = 0;
   int    miscompares = 0;
   string cur_tag = "R11";

   always #2 clk = ~clk;

   slp_ctrl #(.STARTUP_CYC(STARTUP), .HALT_EXTRA(EXTRA)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .sleep_instr(sleep_instr), .adc_on(adc_on), .wake_src(wake_src),
      .wake_rst(wake_rst), .dom_en(dom_en), .osc_en(osc_en),
      .core_halt(core_halt), .rst_vec(rst_vec), .adc_start(adc_start)
   );

   // ---- expectations taken from the requirements ----
   function automatic bit mode_ok(input int m);
      return (m == 0 || m == 1 || m == 2 || m == 3 || m == 6);
   endfunction
   function automatic int dom_of(input int m);
      if (m == 0) return 5'b11100;
      if (m == 1) return 5'b01000;
      return 0;
   endfunction
   function automatic int osc_of(input int m);
      return (m == 2 || m == 3) ? 0 : 1;
   endfunction
   function automatic int mask_of(input int m);
      if (m == 0) return 4'b1111;
      if (m == 1) return 4'b1110;
      return 4'b1010;
   endfunction
   function automatic int hold_of(input int m);
      return (m == 2 || m == 3) ? STARTUP + EXTRA : EXTRA;
   endfunction

   // ---- reference model: phase 0 run, 1 asleep, 2 waking ----
   int m_ph = 0, m_left = 0, m_mode = 0, m_held = 0;
   bit m_en = 0, m_rv = 0, m_adc = 0;

   always @(posedge clk) begin
      bit nx_adc;
      nx_adc = 1'b0;
      if (!rst_n) begin
         m_ph = 0; m_left = 0; m_mode = 0; m_held = 0;
         m_en = 0; m_rv = 0; m_adc = 0;
      end else begin
         if (m_ph == 0) begin
            if (sleep_instr && m_en && mode_ok(m_mode)) begin
               m_ph = 1; m_held = m_mode; m_rv = 0;
               nx_adc = adc_on && (m_mode == 0 || m_mode == 1);
            end
         end else if (m_ph == 1) begin
            if (wake_rst || ((int'(wake_src) & mask_of(m_held)) != 0)) begin
               m_ph = 2; m_rv = wake_rst; m_left = hold_of(m_held);
            end
         end else begin
            m_left--;
            if (m_left == 0) m_ph = 0;
         end
         m_adc = nx_adc;
         if (ctl_we) begin
            m_en = ctl_wdata[0];
            m_mode = int'(ctl_wdata[3:1]);
         end
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_tag, "core_halt", int'(core_halt), (m_ph != 0) ? 1 : 0);
         chk(cur_tag, "dom_en", int'(dom_en), (m_ph == 1) ? dom_of(m_held) : 31);
         chk(cur_tag, "osc_en", int'(osc_en), (m_ph == 1) ? osc_of(m_held) : 1);
         chk(cur_tag, "rst_vec", int'(rst_vec), int'(m_rv));
         chk(cur_tag, "adc_start", int'(adc_start), int'(m_adc));
      end
   end

   task automatic summary_and_end();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog (all requirements): got hung expected done");
      summary_and_end();
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctl(input bit en, input int mode);
      ctl_we = 1'b1;
      ctl_wdata = {3'(mode), en};
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic go_sleep(input int exp_adc, input string tag);
      sleep_instr = 1'b1;
      @(negedge clk);
      sleep_instr = 1'b0;
      chk(tag, "adc_start on entry", int'(adc_start), exp_adc);
   endtask

   task automatic hold_src(input logic [3:0] s, input int n);
      wake_src = s;
      tick(n);
      wake_src = '0;
   endtask

   task automatic timed_wake(input logic [3:0] s, input bit r, input int exp, input string tag);
      int n;
      n = 0;
      wake_src = s;
      wake_rst = r;
      @(negedge clk);
      wake_src = '0;
      wake_rst = 1'b0;
      chk(tag, "clocks restored after wake", int'(dom_en == 5'b11111 && osc_en), 1);
      while (core_halt && n < 1000) begin
         n++;
         @(negedge clk);
      end
      chk(tag, "halt length", n, exp);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "reset halt", int'(core_halt), 0);
      chk("R11", "reset dom_en", int'(dom_en), 31);
      chk("R11", "reset rst_vec", int'(rst_vec), 0);

      cur_tag = "R12";
      wake_rst = 1'b1;
      hold_src(4'hF, 3);
      wake_rst = 1'b0;
      chk("R12", "halt while running", int'(core_halt), 0);

      cur_tag = "R1";
      wr_ctl(1'b0, 0);
      go_sleep(0, "R1");
      tick(2);
      chk("R1", "halt without enable", int'(core_halt), 0);

      cur_tag = "R2";
      for (int m = 4; m < 8; m++) begin
         if (m != 6) begin
            wr_ctl(1'b1, m);
            go_sleep(0, "R2");
            tick(2);
            chk("R2", "halt on reserved code", int'(core_halt), 0);
         end
      end

      cur_tag = "R3";
      adc_on = 1'b1;
      wr_ctl(1'b1, 0);
      go_sleep(1, "R10");
      tick(2);
      chk("R3", "idle dom_en", int'(dom_en), 5'b11100);
      cur_tag = "R8";
      timed_wake(4'b0001, 1'b0, EXTRA, "R8");

      cur_tag = "R4";
      wr_ctl(1'b1, 1);
      go_sleep(1, "R10");
      chk("R4", "adc quiet dom_en", int'(dom_en), 5'b01000);
      cur_tag = "R7";
      hold_src(4'b0001, 4);
      chk("R7", "edge ignored in adc quiet", int'(core_halt), 1);
      timed_wake(4'b0100, 1'b0, EXTRA, "R7");

      cur_tag = "R5";
      wr_ctl(1'b1, 2);
      go_sleep(0, "R10");
      chk("R5", "power-down osc_en", int'(osc_en), 0);
      cur_tag = "R7";
      hold_src(4'b0101, 5);
      chk("R7", "edge and clocked ignored in power-down", int'(core_halt), 1);
      cur_tag = "R8";
      timed_wake(4'b0010, 1'b0, STARTUP + EXTRA, "R8");

      cur_tag = "R5";
      adc_on = 1'b0;
      wr_ctl(1'b1, 3);
      go_sleep(0, "R5");
      chk("R5", "power-save dom_en", int'(dom_en), 0);
      timed_wake(4'b1000, 1'b0, STARTUP + EXTRA, "R8");

      cur_tag = "R6";
      wr_ctl(1'b1, 6);
      go_sleep(0, "R6");
      chk("R6", "standby osc_en", int'(osc_en), 1);
      chk("R6", "standby dom_en", int'(dom_en), 0);
      hold_src(4'b0100, 3);
      chk("R7", "clocked ignored in standby", int'(core_halt), 1);
      timed_wake(4'b0010, 1'b0, EXTRA, "R8");

      cur_tag = "R9";
      wr_ctl(1'b1, 2);
      go_sleep(0, "R9");
      tick(2);
      timed_wake(4'b0000, 1'b1, STARTUP + EXTRA, "R9");
      chk("R9", "rst_vec after reset wake", int'(rst_vec), 1);
      wr_ctl(1'b1, 0);
      go_sleep(0, "R9");
      chk("R9", "rst_vec cleared on entry", int'(rst_vec), 0);
      timed_wake(4'b1000, 1'b0, EXTRA, "R9");
      chk("R9", "rst_vec after interrupt wake", int'(rst_vec), 0);

      tick(3);
      summary_and_end();
   end

endmodule